// File: doc/BRIEF.md
# EOI Handler with Storm Throttle

This block turns end-of-interrupt notices from a processor into per-pin work for an interrupt router. Each notice carries a vector, a flag that says whether the interrupt being retired was level-triggered, and a flag that says the processor retires it with a directed EOI. The block walks the redirection entries one pin per cycle, in ascending pin order. Every pin whose programmed vector equals the notice's vector receives an acknowledge pulse. For a level notice that is not directed, the pin's remote-IRR is also cleared. A pin that is still requesting and not masked is then serviced again straight away.

A pin that is serviced again on every EOI is a possible interrupt storm. Each pin counts its back-to-back re-deliveries. When the count reaches a programmable limit, the counter returns to zero and the block does not re-deliver at once. Instead it arms a timer. When the timer expires, a sweep requests service, in one cycle, for every level-triggered pin that is requesting and whose remote-IRR is clear. Delivery itself, the remote-IRR storage and register access all belong to neighbouring logic. This block only produces pulses: acknowledge, remote-IRR clear and service request.

Top module: `eoi_storm_throttle`

## Requirements
- R1: During the scan, each pin whose vector field matches the notice's vector gets a one-cycle pulse on `ack_o` at its bit position. This happens whatever the level and directed flags are. No other pin gets an acknowledge pulse.
- R2: A notice with `eoi_level_i`=0, or with `eoi_directed_i`=1, gives no remote-IRR clear and no service request. It also leaves the pin's successive-EOI counter unchanged.
- R3: A level notice (`eoi_level_i`=1) with `eoi_directed_i`=0 pulses `rirr_clr_o` for every matching pin, in the same cycle as that pin's acknowledge.
- R4: For a level, non-directed match on a pin that is unmasked (`cfg_mask_i` bit 0) and requesting (`irr_i` bit 1), the counter increments and `svc_req_o` pulses for that pin in the same cycle, provided the new count is below `STORM_LIMIT`. If the pin is masked or not requesting, no service request is made and the counter returns to 0.
- R5: When the increment would reach `STORM_LIMIT`, no immediate service request is made. The counter returns to 0 and a deferred sweep is armed.
- R6: The sweep fires exactly `DEFER_CYCLES` cycles after the scan cycle that armed it. For one cycle, `svc_req_o` then equals `cfg_level_i & irr_i & ~rirr_i`, and the mask bits play no part.
- R7: A storm found while a sweep is already pending, other than in the sweep's own firing cycle, does not restart the timer. The single sweep keeps its original time.
- R8: A notice is accepted when `eoi_valid_i` is 1 at a clock edge while `busy_o` is 0. `busy_o` then stays high for exactly `NPINS` cycles, and the cycle after acceptance handles pin 0, the next pin 1, and so on. A notice offered while `busy_o` is high is dropped.
- R9: Reset leaves `busy_o` low and all pulse outputs at zero. It clears every counter and cancels a pending sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoi_valid_i | input | 1 | EOI notice offered |
| eoi_vector_i | input | VEC_W | Vector being retired |
| eoi_level_i | input | 1 | 1: the retired interrupt was level-triggered |
| eoi_directed_i | input | 1 | 1: processor uses directed EOI, leave remote-IRR alone |
| cfg_vector_i | input | NPINS*VEC_W | Vector field of each entry, pin p at bits p*VEC_W upward |
| cfg_level_i | input | NPINS | Entry trigger mode, 1 = level |
| cfg_mask_i | input | NPINS | Entry mask, 1 = masked |
| irr_i | input | NPINS | Request bit per pin |
| rirr_i | input | NPINS | Remote-IRR per pin |
| busy_o | output | 1 | Scan in progress, new notices dropped |
| ack_o | output | NPINS | Acknowledge pulse per pin |
| rirr_clr_o | output | NPINS | Remote-IRR clear pulse per pin |
| svc_req_o | output | NPINS | Service request pulse per pin |

## Verification
The bench drives notices against a table in which several pins share one vector. Each shared pin is set up differently: one is unmasked and requesting, one has no request, and one is masked. A single scan therefore tells acknowledge, clear and service apart pin by pin and shows each pulse in its own cycle. Edge and directed notices are placed between level notices in a run toward the limit. The storm then arrives one EOI late if those notices disturbed the counter. A dropped request likewise restarts the count, which shifts the storm later. Storm runs check when the sweep fires and which pins it covers. They also check that a second storm during the wait adds no sweep, and that reset cancels a pending one.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_st_e;
endpackage

// File: rtl/eoi_scan_ctrl.sv
module eoi_scan_ctrl
    import eoi_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int VEC_W = 8,
    localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_valid_i,
    input  logic [VEC_W-1:0] eoi_vector_i,
    input  logic             eoi_level_i,
    input  logic             eoi_directed_i,
    output logic             busy_o,
    output logic [IW-1:0]    idx_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             lvl_clr_o
);
    localparam logic [IW-1:0] LAST = IW'(NPINS - 1);

    typedef struct packed {
        scan_st_e         st;
        logic [IW-1:0]    idx;
        logic [VEC_W-1:0] vec;
        logic             lvl_clr;
    } scan_t;

    scan_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SCAN_IDLE: begin
                if (eoi_valid_i) begin
                    s_d.st      = SCAN_RUN;
                    s_d.idx     = '0;
                    s_d.vec     = eoi_vector_i;
                    s_d.lvl_clr = eoi_level_i && !eoi_directed_i;
                end
            end
            default: begin
                if (s_q.idx == LAST) begin
                    s_d.st = SCAN_IDLE;
                end else begin
                    s_d.idx = s_q.idx + IW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SCAN_IDLE, idx: '0, vec: '0, lvl_clr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = (s_q.st == SCAN_RUN);
    assign idx_o     = s_q.idx;
    assign vec_o     = s_q.vec;
    assign lvl_clr_o = s_q.lvl_clr;

    // R8: the scan advances one pin per cycle
    p_scan_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && idx_o != LAST) |=> (busy_o && idx_o == $past(idx_o) + IW'(1)));

    // R8: the scan ends right after the last pin
    p_scan_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && idx_o == LAST) |=> !busy_o);

    // R8: a newly started scan begins at pin 0
    p_scan_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (idx_o == '0));
endmodule

// File: rtl/eoi_storm_cnt.sv
module eoi_storm_cnt #(
    parameter int NPINS       = 8,
    parameter int STORM_LIMIT = 10000,
    localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1,
    localparam int CW = $clog2(STORM_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic          ready_i,
    input  logic [IW-1:0] idx_i,
    output logic          storm_o,
    output logic          redo_o
);
    typedef struct packed {
        logic [NPINS-1:0][CW-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [CW-1:0] nxt;

    always_comb begin
        c_d     = c_q;
        nxt     = c_q.cnt[idx_i] + CW'(1);
        storm_o = upd_i && ready_i && (nxt == CW'(STORM_LIMIT));
        redo_o  = upd_i && ready_i && !storm_o;
        if (upd_i) begin
            c_d.cnt[idx_i] = redo_o ? nxt : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // R5: a storm and an immediate re-service never coincide
    p_storm_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(storm_o && redo_o));

    for (genvar g = 0; g < NPINS; g++) begin : g_pin_chk
        // R5: the count never rests at the limit
        p_cnt_below_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            c_q.cnt[g] < CW'(STORM_LIMIT));
        // R4: an update without a ready pin clears its count
        p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_i && !ready_i && idx_i == IW'(g)) |=> (c_q.cnt[g] == '0));
    end
endmodule

// File: rtl/eoi_defer_timer.sv
module eoi_defer_timer #(
    parameter int DEFER_CYCLES = 500000,
    localparam int TW = (DEFER_CYCLES > 1) ? $clog2(DEFER_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic fire_o
);
    typedef struct packed {
        logic          pend;
        logic [TW-1:0] tmr;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d    = t_q;
        fire_o = t_q.pend && (t_q.tmr == '0);
        if (arm_i && (!t_q.pend || fire_o)) begin
            t_d.pend = 1'b1;
            t_d.tmr  = TW'(DEFER_CYCLES - 1);
        end else if (fire_o) begin
            t_d.pend = 1'b0;
        end else if (t_q.pend) begin
            t_d.tmr = t_q.tmr - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    // R7: a pending count runs down undisturbed by further arming
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.pend && t_q.tmr != '0) |=> (t_q.pend && t_q.tmr == $past(t_q.tmr) - TW'(1)));

    // R6: the sweep is a single-cycle event unless re-armed
    p_fire_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !arm_i) |=> !t_q.pend);
endmodule

// File: rtl/eoi_storm_throttle.sv
module eoi_storm_throttle #(
    parameter int NPINS        = 8,
    parameter int VEC_W        = 8,
    parameter int STORM_LIMIT  = 10000,
    parameter int DEFER_CYCLES = 500000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   eoi_valid_i,
    input  logic [VEC_W-1:0]       eoi_vector_i,
    input  logic                   eoi_level_i,
    input  logic                   eoi_directed_i,
    input  logic [NPINS*VEC_W-1:0] cfg_vector_i,
    input  logic [NPINS-1:0]       cfg_level_i,
    input  logic [NPINS-1:0]       cfg_mask_i,
    input  logic [NPINS-1:0]       irr_i,
    input  logic [NPINS-1:0]       rirr_i,
    output logic                   busy_o,
    output logic [NPINS-1:0]       ack_o,
    output logic [NPINS-1:0]       rirr_clr_o,
    output logic [NPINS-1:0]       svc_req_o
);
    localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;

    logic [VEC_W-1:0] ent_vec [NPINS];
    logic [IW-1:0]    cur_idx;
    logic [VEC_W-1:0] cur_vec;
    logic             lvl_clr;
    logic             hit;
    logic             upd;
    logic             ready;
    logic             storm;
    logic             redo;
    logic             fire;
    logic [NPINS-1:0] sel;

    for (genvar g = 0; g < NPINS; g++) begin : g_vec
        assign ent_vec[g] = cfg_vector_i[g*VEC_W +: VEC_W];
    end

    eoi_scan_ctrl #(.NPINS(NPINS), .VEC_W(VEC_W)) u_scan (
        .clk           (clk),
        .rst_n         (rst_n),
        .eoi_valid_i   (eoi_valid_i),
        .eoi_vector_i  (eoi_vector_i),
        .eoi_level_i   (eoi_level_i),
        .eoi_directed_i(eoi_directed_i),
        .busy_o        (busy_o),
        .idx_o         (cur_idx),
        .vec_o         (cur_vec),
        .lvl_clr_o     (lvl_clr)
    );

    always_comb begin
        sel   = NPINS'(1) << cur_idx;
        hit   = busy_o && (ent_vec[cur_idx] == cur_vec);
        upd   = hit && lvl_clr;
        ready = !cfg_mask_i[cur_idx] && irr_i[cur_idx];
    end

    eoi_storm_cnt #(.NPINS(NPINS), .STORM_LIMIT(STORM_LIMIT)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (upd),
        .ready_i(ready),
        .idx_i  (cur_idx),
        .storm_o(storm),
        .redo_o (redo)
    );

    eoi_defer_timer #(.DEFER_CYCLES(DEFER_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .arm_i (storm),
        .fire_o(fire)
    );

    always_comb begin
        ack_o      = hit ? sel : '0;
        rirr_clr_o = upd ? sel : '0;
        svc_req_o  = (redo ? sel : '0)
                   | (fire ? (cfg_level_i & irr_i & ~rirr_i) : '0);
    end

    // R1: at most one pin is acknowledged per cycle
    p_ack_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    // R3: a remote-IRR clear only accompanies an acknowledge
    p_clr_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rirr_clr_o & ~ack_o) == '0));

    // R8: no scan pulses while idle
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ack_o == '0 && rirr_clr_o == '0));
endmodule

// File: tb/tb_eoi_storm_throttle.sv
module tb_eoi_storm_throttle;
    localparam int N     = 4;
    localparam int VW    = 8;
    localparam int LIM   = 4;
    localparam int DEFER = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eoi_valid = 1'b0;
    logic [VW-1:0] eoi_vec = '0;
    logic eoi_lvl = 1'b0;
    logic eoi_dir = 1'b0;
    logic [N*VW-1:0] cfg_vec = '0;
    logic [N-1:0] cfg_lvl = '0, cfg_mask = '0, irr = '0, rirr = '0;
    logic busy;
    logic [N-1:0] ack, clr, svc;

    int checks = 0, fails = 0, cyc = 0;
    int sweeps = 0, last_sweep_cyc = 0;
    logic [N-1:0] last_sweep_bits = '0;
    logic [N-1:0] acc_ack, acc_clr, acc_svc;
    int pos_err, scan0_cyc;
    logic end_busy;

    eoi_storm_throttle #(.NPINS(N), .VEC_W(VW), .STORM_LIMIT(LIM), .DEFER_CYCLES(DEFER)) dut (
        .clk(clk), .rst_n(rst_n), .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vec),
        .eoi_level_i(eoi_lvl), .eoi_directed_i(eoi_dir), .cfg_vector_i(cfg_vec),
        .cfg_level_i(cfg_lvl), .cfg_mask_i(cfg_mask), .irr_i(irr), .rirr_i(rirr),
        .busy_o(busy), .ack_o(ack), .rirr_clr_o(clr), .svc_req_o(svc));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && !busy && (svc != '0)) begin
            sweeps++;
            last_sweep_cyc = cyc;
            last_sweep_bits = svc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        eoi_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_eoi(input logic [VW-1:0] v, input logic lvl, input logic dir, input bit poke);
        acc_ack = '0; acc_clr = '0; acc_svc = '0; pos_err = 0;
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vec = v; eoi_lvl = lvl; eoi_dir = dir;
        @(negedge clk);
        eoi_valid = 1'b0;
        for (int p = 0; p < N; p++) begin
            if (!busy) pos_err++;
            if (p == 0) scan0_cyc = cyc;
            acc_ack |= ack; acc_clr |= clr; acc_svc |= svc;
            if (((ack | clr | svc) & ~(N'(1) << p)) != '0) pos_err++;
            if (poke && p == 1) begin
                eoi_valid = 1'b1; eoi_vec = 8'h31;
            end else begin
                eoi_valid = 1'b0;
            end
            @(negedge clk);
        end
        eoi_valid = 1'b0;
        end_busy = busy;
    endtask

    function automatic void storm_cfg();
        cfg_vec  = {8'h43, 8'h42, 8'h41, 8'h40};
        cfg_lvl  = 4'b0111;
        cfg_mask = 4'b0010;
        irr      = 4'b1111;
        rirr     = 4'b0100;
    endfunction

    task automatic t_reset_state();
        do_reset();
        chk("R9 busy after reset", busy, 0);
        chk("R9 ack after reset", ack, 0);
        chk("R9 clr after reset", clr, 0);
        chk("R9 svc after reset", svc, 0);
    endtask

    task automatic t_shared_vector();
        do_reset();
        cfg_vec  = {8'h30, 8'h30, 8'h31, 8'h30};
        cfg_lvl  = 4'b1111;
        cfg_mask = 4'b1000;
        irr      = 4'b1011;
        rirr     = 4'b0000;
        do_eoi(8'h30, 1'b1, 1'b0, 1'b0);
        chk("R1 ack on matching pins", acc_ack, 4'b1101);
        chk("R3 clr on matching pins", acc_clr, 4'b1101);
        chk("R4 svc only ready pin", acc_svc, 4'b0001);
        chk("R8 one pin per cycle in order", pos_err, 0);
        chk("R8 busy drops after N cycles", end_busy, 0);
        do_eoi(8'h30, 1'b0, 1'b0, 1'b0);
        chk("R2 edge notice ack", acc_ack, 4'b1101);
        chk("R2 edge notice no clr", acc_clr, 0);
        chk("R2 edge notice no svc", acc_svc, 0);
        do_eoi(8'h30, 1'b1, 1'b1, 1'b0);
        chk("R1 directed notice ack", acc_ack, 4'b1101);
        chk("R2 directed notice no clr", acc_clr, 0);
        chk("R2 directed notice no svc", acc_svc, 0);
    endtask

    task automatic t_busy_drop();
        do_reset();
        cfg_vec  = {8'h30, 8'h30, 8'h31, 8'h30};
        cfg_lvl  = 4'b1111;
        cfg_mask = 4'b0000;
        irr      = 4'b0000;
        rirr     = 4'b0000;
        do_eoi(8'h30, 1'b1, 1'b0, 1'b1);
        chk("R8 poked notice not scanned", acc_ack[1], 0);
        @(negedge clk);
        chk("R8 no scan after drop busy", busy, 0);
        chk("R8 no scan after drop ack", ack, 0);
    endtask

    task automatic t_counter_rules();
        do_reset();
        storm_cfg();
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        chk("R4 second redo", acc_svc, 4'b0001);
        do_eoi(8'h40, 1'b0, 1'b0, 1'b0);
        do_eoi(8'h40, 1'b1, 1'b1, 1'b0);
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        chk("R2 counter kept, third redo", acc_svc, 4'b0001);
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        chk("R5 fourth is storm, no svc", acc_svc, 0);
        chk("R5 storm still clears", acc_clr, 4'b0001);
        do_reset();
        storm_cfg();
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        irr[0] = 1'b0;
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        chk("R4 no svc without request", acc_svc, 0);
        irr[0] = 1'b1;
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        chk("R4 counter restarted, third redo", acc_svc, 4'b0001);
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        chk("R5 storm after restart", acc_svc, 0);
    endtask

    task automatic t_sweep();
        int s0, a;
        do_reset();
        storm_cfg();
        s0 = sweeps;
        repeat (LIM) do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        a = scan0_cyc;
        repeat (DEFER + 5) @(negedge clk);
        chk("R6 one sweep", sweeps - s0, 1);
        chk("R6 sweep timing", last_sweep_cyc - a, DEFER);
        chk("R6 sweep pins", last_sweep_bits, 4'b0011);
    endtask

    task automatic t_no_restart();
        int s0, a;
        do_reset();
        storm_cfg();
        s0 = sweeps;
        repeat (LIM) do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        a = scan0_cyc;
        repeat (LIM) do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        chk("R7 second storm seen", acc_svc, 0);
        repeat (DEFER + 10) @(negedge clk);
        chk("R7 single sweep", sweeps - s0, 1);
        chk("R7 sweep keeps first time", last_sweep_cyc - a, DEFER);
    endtask

    task automatic t_reset_cancel();
        int s0;
        do_reset();
        storm_cfg();
        repeat (LIM) do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        s0 = sweeps;
        do_reset();
        repeat (DEFER + 10) @(negedge clk);
        chk("R9 reset cancels sweep", sweeps - s0, 0);
        do_eoi(8'h40, 1'b1, 1'b0, 1'b0);
        chk("R9 counter cleared by reset", acc_svc, 4'b0001);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_shared_vector();
        t_busy_drop();
        t_counter_rules();
        t_sweep();
        t_no_restart();
        t_reset_cancel();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule